// File: doc/BRIEF.md
# Event Timer with Comparator Channels

A memory-mapped event timer. A 64-bit main counter advances by one on every clock while the global run bit is set. While that bit is clear, the counter holds its value and software may load it. Each comparator channel watches the counter and raises a sticky interrupt status bit when the counter reaches or passes its compare value.

A channel works in one of two modes. In one-shot mode it fires once and then disarms. In periodic mode it adds a stored interval to its compare value each time it fires. The interval is loaded by a short sequence: setting the set-value flag in the channel configuration, then two comparator writes, the first giving the compare value and the second the interval. A channel may compare all 64 bits, or only the low 32 bits as a signed difference, so that it survives a wrap of the low word.

A routing option moves channel 0 and channel 1 off their own interrupt lines and onto two fixed outputs: a system tick line and a real-time-clock line. Software reads identification and tick-period words to discover how many channels exist and how fast the counter ticks.

Top module: `evt_timer`

## Requirements
- R1: After reset, the global configuration reads 0, both counter halves read 0, the status word reads 0, every comparator half reads 0xFFFF_FFFF, and all interrupt outputs are low.
- R2: The identification word at byte address 0x000 reads revision 0x01 in bits [7:0], the channel count minus one in bits [12:8], and the routing-capable flag in bit 15. The default reads 0x0000_8101. The word at 0x004 reads the tick period in femtoseconds, with a default of 10_000_000, which elaboration keeps within 100_000 to 100_000_000.
- R3: The global configuration at 0x010 has its run bit at bit 0. While run is set, the counter increments once per clock and writes to its halves (low at 0xF0, high at 0xF4) are ignored. While run is clear, the counter holds and those writes load it.
- R4: Channel n has its configuration at 0x100+0x20·n, its compare low half at +0x08 and its compare high half at +0x0C. Configuration bits are: bit 0 enable, bit 1 periodic, bit 2 set-value (reads 0), bit 3 32-bit mode. A compare write arms the channel. An armed, enabled one-shot channel sets its status bit on the clock edge after the counter first equals or passes the compare value, then disarms, leaving the compare value unchanged.
- R5: Writing a configuration word with both periodic and set-value set makes the next compare-low write load the compare value and the one after it load the interval. Each periodic firing adds the interval to the compare value.
- R6: In 32-bit mode the match tests the sign of (counter low − compare low) in 32 bits, and compare-high writes are ignored. In 64-bit mode the match tests the sign of the full 64-bit difference.
- R7: The status word at 0x020 holds one sticky bit per channel (bit n for channel n), cleared by writing 1 to it. A disabled channel never sets its bit.
- R8: With the route bit (bit 1 of the global configuration) set, status bits 0 and 1 drive the tick and RTC outputs and are removed from their own interrupt lines. With it clear, both fixed outputs stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | Write when high, with req_i |
| addr_i | input | 12 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| irq_o | output | NUM_CH | Per-channel interrupt lines |
| tick_irq_o | output | 1 | Routed channel 0 interrupt |
| rtc_irq_o | output | 1 | Routed channel 1 interrupt |

## Verification
The bench targets the exact firing cycle of a one-shot channel. A compare that tested "greater than" or read the counter one stage late would move the status bit by one edge. A one-shot channel that failed to disarm would set its bit again after a clear. A counter low half just below the 32-bit wrap, paired with a small compare value, separates the signed 32-bit test from an unsigned or 64-bit one: the wrong test would fire at once, or never. The set-value sequence is read back after several periodic firings, which exposes an interval written over the compare value or a missing reload. Counter writes are issued while running, and routing is toggled with both status bits set.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
  localparam int unsigned DW = 32;
  localparam int unsigned AW = 12;
  localparam int unsigned CW = 64;

  localparam logic [AW-1:0] A_ID     = 12'h000;
  localparam logic [AW-1:0] A_PERIOD = 12'h004;
  localparam logic [AW-1:0] A_GCFG   = 12'h010;
  localparam logic [AW-1:0] A_STS    = 12'h020;
  localparam logic [AW-1:0] A_CNT_LO = 12'h0F0;
  localparam logic [AW-1:0] A_CNT_HI = 12'h0F4;
  localparam logic [3:0]    CH_PAGE  = 4'h1;
  localparam logic [4:0]    O_CFG    = 5'h00;
  localparam logic [4:0]    O_CMP_LO = 5'h08;
  localparam logic [4:0]    O_CMP_HI = 5'h0C;

  localparam int unsigned GB_RUN   = 0;
  localparam int unsigned GB_ROUTE = 1;
  localparam int unsigned CB_EN    = 0;
  localparam int unsigned CB_PER   = 1;
  localparam int unsigned CB_SETV  = 2;
  localparam int unsigned CB_M32   = 3;

  localparam logic [7:0] REV = 8'h01;
  localparam logic [31:0] MIN_PERIOD_FS = 32'd100_000;
  localparam logic [31:0] MAX_PERIOD_FS = 32'd100_000_000;

  typedef enum logic [1:0] {
    LD_CMP   = 2'd0,  // compare write loads compare value
    LD_FIRST = 2'd1,  // after set-value: next write is compare
    LD_IVL   = 2'd2   // next write is interval
  } ld_phase_e;
endpackage

// File: rtl/evt_main_cnt.sv
module evt_main_cnt
  import evt_timer_pkg::*;
#(
  parameter int unsigned W = CW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          wr_lo_i,
  input  logic          wr_hi_i,
  input  logic [DW-1:0] wdata_i,
  output logic [W-1:0]  cnt_o
);
  localparam int unsigned HW = W - DW;
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (run_i) begin
      cnt_q <= cnt_q + W'(1);
    end else begin
      if (wr_lo_i) cnt_q[DW-1:0] <= wdata_i;
      if (wr_hi_i) cnt_q[W-1:DW] <= wdata_i[HW-1:0];
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/evt_chan.sv
module evt_chan
  import evt_timer_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          cfg_we_i,
  input  logic          lo_we_i,
  input  logic          hi_we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] cfg_o,
  output logic [CW-1:0] cmp_o,
  output logic          fire_o,
  output logic          armed_o,
  output logic          per_o
);
  logic          en_q, per_q, m32_q, armed_q;
  logic [CW-1:0] cmp_q, ivl_q;
  ld_phase_e     phase_q;

  logic [CW-1:0] diff64;
  logic [DW-1:0] diff32;
  logic          reached, fire;

  assign diff64  = cnt_i - cmp_q;
  assign diff32  = cnt_i[DW-1:0] - cmp_q[DW-1:0];
  assign reached = m32_q ? !diff32[DW-1] : !diff64[CW-1];
  assign fire    = run_i & en_q & armed_q & reached;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      per_q   <= 1'b0;
      m32_q   <= 1'b0;
      armed_q <= 1'b0;
      cmp_q   <= '1;
      ivl_q   <= '0;
      phase_q <= LD_CMP;
    end else begin
      if (cfg_we_i) begin
        en_q  <= wdata_i[CB_EN];
        per_q <= wdata_i[CB_PER];
        m32_q <= wdata_i[CB_M32];
        if (wdata_i[CB_SETV] && wdata_i[CB_PER]) phase_q <= LD_FIRST;
        else if (!wdata_i[CB_PER])               phase_q <= LD_CMP;
      end
      if (lo_we_i) begin
        unique case (phase_q)
          LD_IVL: begin
            ivl_q[DW-1:0] <= wdata_i;
            phase_q       <= LD_CMP;
          end
          LD_FIRST: begin
            cmp_q[DW-1:0] <= wdata_i;
            armed_q       <= 1'b1;
            phase_q       <= LD_IVL;
          end
          default: begin
            cmp_q[DW-1:0] <= wdata_i;
            armed_q       <= 1'b1;
          end
        endcase
      end else if (hi_we_i && !m32_q) begin
        if (phase_q == LD_IVL) begin
          ivl_q[CW-1:DW] <= wdata_i;
        end else begin
          cmp_q[CW-1:DW] <= wdata_i;
          armed_q        <= 1'b1;
        end
      end else if (fire) begin
        if (per_q) begin
          if (m32_q) cmp_q[DW-1:0] <= cmp_q[DW-1:0] + ivl_q[DW-1:0];
          else       cmp_q         <= cmp_q + ivl_q;
        end else begin
          armed_q <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    cfg_o         = '0;
    cfg_o[CB_EN]  = en_q;
    cfg_o[CB_PER] = per_q;
    cfg_o[CB_M32] = m32_q;
  end

  assign cmp_o   = cmp_q;
  assign fire_o  = fire;
  assign armed_o = armed_q;
  assign per_o   = per_q;
endmodule

// File: rtl/evt_irq_route.sv
module evt_irq_route #(
  parameter int unsigned N = 2
) (
  input  logic         route_i,
  input  logic [N-1:0] sts_i,
  output logic [N-1:0] irq_o,
  output logic         tick_o,
  output logic         rtc_o
);
  for (genvar i = 0; i < N; i++) begin : g_line
    if (i < 2) begin : g_fixed
      assign irq_o[i] = sts_i[i] & ~route_i;
    end else begin : g_plain
      assign irq_o[i] = sts_i[i];
    end
  end

  assign tick_o = route_i & sts_i[0];
  assign rtc_o  = route_i & sts_i[1];
endmodule

// File: rtl/evt_timer.sv
module evt_timer
  import evt_timer_pkg::*;
#(
  parameter int unsigned NUM_CH     = 2,
  parameter logic [31:0] PERIOD_FS  = 32'd10_000_000,
  parameter bit          ROUTE_CAP  = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic [NUM_CH-1:0] irq_o,
  output logic              tick_irq_o,
  output logic              rtc_irq_o
);
  localparam logic [4:0] NCH_M1 = 5'(NUM_CH - 1);
  localparam logic [DW-1:0] ID_WORD = {16'h0, ROUTE_CAP, 2'b00, NCH_M1, REV};

  if (NUM_CH < 2 || NUM_CH > 8) begin : g_bad_ch
    $error("evt_timer: NUM_CH must be 2..8");
  end
  if (PERIOD_FS < MIN_PERIOD_FS || PERIOD_FS > MAX_PERIOD_FS) begin : g_bad_per
    $error("evt_timer: PERIOD_FS out of range");
  end

  logic              wr;
  logic              run_q, route_q;
  logic              gcfg_we, sts_we, cnt_wr_lo, cnt_wr_hi, cnt_wr;
  logic [CW-1:0]     cnt_q;
  logic [NUM_CH-1:0] sts_q, sts_clr;
  logic [NUM_CH-1:0] fire_v, armed_v, per_v, cmpwr_v;
  logic              ch_hit;
  logic [2:0]        ch_sel;
  logic [4:0]        ch_ofs;
  logic [DW-1:0]     ch_cfg [NUM_CH];
  logic [CW-1:0]     ch_cmp [NUM_CH];

  assign wr        = req_i & we_i;
  assign gcfg_we   = wr && addr_i == A_GCFG;
  assign sts_we    = wr && addr_i == A_STS;
  assign cnt_wr_lo = wr && addr_i == A_CNT_LO && !run_q;
  assign cnt_wr_hi = wr && addr_i == A_CNT_HI && !run_q;
  assign cnt_wr    = cnt_wr_lo | cnt_wr_hi;
  assign ch_hit    = addr_i[11:8] == CH_PAGE;
  assign ch_sel    = addr_i[7:5];
  assign ch_ofs    = addr_i[4:0];
  assign sts_clr   = sts_we ? wdata_i[NUM_CH-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      route_q <= 1'b0;
      sts_q   <= '0;
    end else begin
      if (gcfg_we) begin
        run_q   <= wdata_i[GB_RUN];
        route_q <= wdata_i[GB_ROUTE] & ROUTE_CAP;
      end
      sts_q <= (sts_q & ~sts_clr) | fire_v;
    end
  end

  evt_main_cnt #(.W(CW)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run_q),
    .wr_lo_i (cnt_wr_lo),
    .wr_hi_i (cnt_wr_hi),
    .wdata_i (wdata_i),
    .cnt_o   (cnt_q)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam logic [2:0] IDX = 3'(i);
    logic sel, lo_we, hi_we;
    assign sel        = wr && ch_hit && ch_sel == IDX;
    assign lo_we      = sel && ch_ofs == O_CMP_LO;
    assign hi_we      = sel && ch_ofs == O_CMP_HI;
    assign cmpwr_v[i] = lo_we | hi_we;

    evt_chan u_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .run_i    (run_q),
      .cnt_i    (cnt_q),
      .cfg_we_i (sel && ch_ofs == O_CFG),
      .lo_we_i  (lo_we),
      .hi_we_i  (hi_we),
      .wdata_i  (wdata_i),
      .cfg_o    (ch_cfg[i]),
      .cmp_o    (ch_cmp[i]),
      .fire_o   (fire_v[i]),
      .armed_o  (armed_v[i]),
      .per_o    (per_v[i])
    );
  end

  evt_irq_route #(.N(NUM_CH)) u_route (
    .route_i (route_q),
    .sts_i   (sts_q),
    .irq_o   (irq_o),
    .tick_o  (tick_irq_o),
    .rtc_o   (rtc_irq_o)
  );

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_ID:     rdata_o = ID_WORD;
      A_PERIOD: rdata_o = PERIOD_FS;
      A_GCFG:   rdata_o = {30'h0, route_q, run_q};
      A_STS:    rdata_o = DW'(sts_q);
      A_CNT_LO: rdata_o = cnt_q[DW-1:0];
      A_CNT_HI: rdata_o = cnt_q[CW-1:DW];
      default: begin
        for (int i = 0; i < NUM_CH; i++) begin
          if (ch_hit && ch_sel == 3'(i)) begin
            if (ch_ofs == O_CFG)         rdata_o = ch_cfg[i];
            else if (ch_ofs == O_CMP_LO) rdata_o = ch_cmp[i][DW-1:0];
            else if (ch_ofs == O_CMP_HI) rdata_o = ch_cmp[i][CW-1:DW];
          end
        end
      end
    endcase
  end
endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk #(
  parameter int unsigned NUM_CH = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              run_q,
  input logic              route_q,
  input logic              cnt_wr,
  input logic [63:0]       cnt_q,
  input logic [NUM_CH-1:0] sts_q,
  input logic [NUM_CH-1:0] sts_clr,
  input logic [NUM_CH-1:0] fire_v,
  input logic [NUM_CH-1:0] armed_v,
  input logic [NUM_CH-1:0] per_v,
  input logic [NUM_CH-1:0] cmpwr_v,
  input logic [NUM_CH-1:0] irq_o,
  input logic              tick_irq_o,
  input logic              rtc_irq_o
);
  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && !cnt_wr) |=> $stable(cnt_q)); // R3
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |=> cnt_q == $past(cnt_q) + 64'd1); // R3
  AST_FIRE_NEEDS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_v != '0) |-> run_q); // R3
  AST_STS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(sts_q) & ~$past(sts_clr) & ~sts_q) == '0)); // R7
  AST_STS_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((sts_q & ~$past(sts_q) & ~$past(fire_v)) == '0)); // R4
  AST_ROUTE_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    route_q |-> irq_o[1:0] == 2'b00); // R8
  AST_ROUTE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !route_q |-> !tick_irq_o && !rtc_irq_o); // R8

  for (genvar i = 0; i < NUM_CH; i++) begin : g_c
    AST_ONESHOT_DISARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fire_v[i] && !per_v[i] && !cmpwr_v[i]) |=> !armed_v[i]); // R4
  end
endmodule

bind evt_timer evt_timer_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .run_q      (run_q),
  .route_q    (route_q),
  .cnt_wr     (cnt_wr),
  .cnt_q      (cnt_q),
  .sts_q      (sts_q),
  .sts_clr    (sts_clr),
  .fire_v     (fire_v),
  .armed_v    (armed_v),
  .per_v      (per_v),
  .cmpwr_v    (cmpwr_v),
  .irq_o      (irq_o),
  .tick_irq_o (tick_irq_o),
  .rtc_irq_o  (rtc_irq_o)
);

// File: tb/evt_timer_tb.sv
`timescale 1ns/1ps
module evt_timer_tb_top;
  localparam logic [11:0] A_ID = 12'h000, A_PER = 12'h004, A_GCFG = 12'h010;
  localparam logic [11:0] A_STS = 12'h020, A_CLO = 12'h0F0, A_CHI = 12'h0F4;
  localparam logic [11:0] C0_CFG = 12'h100, C0_LO = 12'h108, C0_HI = 12'h10C;
  localparam logic [11:0] C1_CFG = 12'h120, C1_LO = 12'h128, C1_HI = 12'h12C;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [1:0]  irq;
  logic        tick_irq, rtc_irq;
  int          n_chk = 0, n_err = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  evt_timer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq),
    .tick_irq_o(tick_irq), .rtc_irq_o(rtc_irq)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    #1;
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    addr = a; we = 1'b0;
    #1;
    d = rdata;
  endtask

  // counter advances m+1 times
  task automatic run_for(int m);
    wr(A_GCFG, 32'h1);
    repeat (m) @(posedge clk);
    wr(A_GCFG, 32'h0);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(A_GCFG, d);  chk("R1 gcfg", d, 32'h0);
    rd(A_CLO, d);   chk("R1 cnt lo", d, 32'h0);
    rd(A_CHI, d);   chk("R1 cnt hi", d, 32'h0);
    rd(A_STS, d);   chk("R1 status", d, 32'h0);
    rd(C0_LO, d);   chk("R1 cmp0 lo", d, 32'hFFFF_FFFF);
    rd(C1_HI, d);   chk("R1 cmp1 hi", d, 32'hFFFF_FFFF);
    chk("R1 irq lines", {29'h0, irq, tick_irq, rtc_irq}, 32'h0);
  endtask

  task automatic t_ident();
    logic [31:0] d;
    rd(A_ID, d);  chk("R2 id word", d, 32'h0000_8101);
    rd(A_PER, d); chk("R2 period fs", d, 32'd10_000_000);
  endtask

  task automatic t_count();
    logic [31:0] d;
    wr(A_CLO, 32'd100);
    wr(A_CHI, 32'd2);
    rd(A_CLO, d); chk("R3 load lo while stopped", d, 32'd100);
    rd(A_CHI, d); chk("R3 load hi while stopped", d, 32'd2);
    run_for(9);
    rd(A_CLO, d); chk("R3 counts per clock", d, 32'd110);
    wr(A_GCFG, 32'h1);
    wr(A_CLO, 32'd5);
    repeat (3) @(posedge clk);
    wr(A_GCFG, 32'h0);
    rd(A_CLO, d); chk("R3 write ignored while running", d, 32'd115);
    rd(A_CHI, d); chk("R3 hi unchanged", d, 32'd2);
  endtask

  task automatic t_oneshot();
    logic [31:0] d;
    wr(A_CLO, 32'd100);
    wr(A_CHI, 32'd0);
    wr(C0_CFG, 32'h1);
    wr(C0_HI, 32'd0);
    wr(C0_LO, 32'd105);
    wr(A_GCFG, 32'h1);
    repeat (5) @(posedge clk);
    #1; rd(A_STS, d); chk("R4 no fire before match", d, 32'h0);
    @(posedge clk);
    #1; rd(A_STS, d); chk("R4 fires edge after match", d, 32'h1);
    wr(A_STS, 32'h1);
    rd(A_STS, d); chk("R7 write-1 clears", d, 32'h0);
    repeat (20) @(posedge clk);
    #1; rd(A_STS, d); chk("R4 one-shot no refire", d, 32'h0);
    wr(A_GCFG, 32'h0);
    rd(C0_LO, d); chk("R4 compare not reloaded", d, 32'd105);
  endtask

  task automatic t_periodic();
    logic [31:0] d;
    wr(A_CLO, 32'd0);
    wr(A_STS, 32'h3);
    wr(C0_CFG, 32'h7);
    rd(C0_CFG, d); chk("R4 set-value reads 0", d, 32'h3);
    wr(C0_LO, 32'd10);
    wr(C0_LO, 32'd10);
    rd(C0_LO, d); chk("R5 second write is interval", d, 32'd10);
    run_for(34);
    rd(A_CLO, d); chk("R5 counter after run", d, 32'd35);
    rd(C0_LO, d); chk("R5 compare after three reloads", d, 32'd40);
    rd(A_STS, d); chk("R5 periodic status", d, 32'h1);
  endtask

  task automatic t_wrap();
    logic [31:0] d;
    wr(C0_CFG, 32'h0);
    wr(A_STS, 32'h3);
    wr(A_CLO, 32'hFFFF_FFF0);
    wr(A_CHI, 32'd0);
    wr(C1_CFG, 32'h9);
    wr(C1_HI, 32'h0000_1234);
    rd(C1_HI, d); chk("R6 hi write ignored in 32-bit", d, 32'hFFFF_FFFF);
    wr(C1_LO, 32'd5);
    run_for(9);
    rd(A_STS, d); chk("R6 no early match across wrap", d, 32'h0);
    run_for(29);
    rd(A_STS, d); chk("R6 match after wrap", d, 32'h2);
    rd(A_CHI, d); chk("R6 counter carried", d, 32'd1);
    wr(A_STS, 32'h3);
    wr(A_CLO, 32'hFFFF_FFF0);
    wr(A_CHI, 32'd0);
    wr(C1_CFG, 32'h1);
    wr(C1_HI, 32'd0);
    wr(C1_LO, 32'd5);
    run_for(1);
    rd(A_STS, d); chk("R6 64-bit mode fires; R7 disabled ch0 silent", d, 32'h2);
  endtask

  task automatic t_route();
    logic [31:0] d;
    wr(A_CLO, 32'd0);
    wr(C0_CFG, 32'h1);
    wr(C0_HI, 32'd0);
    wr(C0_LO, 32'd2);
    run_for(5);
    rd(A_STS, d); chk("R7 both sticky", d, 32'h3);
    #1;
    chk("R8 route off", {28'h0, irq, tick_irq, rtc_irq}, 32'hC);
    wr(A_GCFG, 32'h2);
    rd(A_GCFG, d); chk("R8 route bit", d, 32'h2);
    chk("R8 route on", {28'h0, irq, tick_irq, rtc_irq}, 32'h3);
    wr(A_STS, 32'h1);
    #1;
    chk("R8 tick cleared rtc kept", {28'h0, irq, tick_irq, rtc_irq}, 32'h1);
    wr(A_GCFG, 32'h0);
    #1;
    chk("R8 route back off", {28'h0, irq, tick_irq, rtc_irq}, 32'h8);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_ident();
    t_count();
    t_oneshot();
    t_periodic();
    t_wrap();
    t_route();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog all requirements actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule